// File: doc/BRIEF.md
# Area-Based External Chip Select Generator

This block splits a 24-bit bus address space into eight equal areas and, for every bus access aimed at external memory, pulls the matching active-low select line low. The area number comes straight from the top three address bits. Area 7 also holds two internal regions: a peripheral register window and an on-chip RAM window. Accesses to the peripheral window never reach the pins. Accesses to the RAM window stay internal only while the RAM enable input is high. When that input is low, they fall through to area 7's external select.

Each select pin drives only while its direction bit is 1. The direction bits sit in a register that software loads synchronously. Their reset value depends on the operating mode. With the internal ROM off, area 0's pin comes out of reset as an output so that the boot memory can be reached. With the ROM on, all eight pins come out of reset as inputs.

Areas 2 to 5 can each be marked as DRAM. For a marked area, the plain select stays high and a row-address strobe for that area goes low instead. The value placed on that area's pin is then the strobe.

Top module: `csgen_top`

## Requirements
- R1: The area number is address bits [23:21]. An access (acc=1 at a rising edge) to a non-DRAM area k outside area 7's internal windows makes cs_n[k] low after that edge, while every other cs_n bit and every ras_n bit stays high.
- R2: After an edge with acc=0, cs_n, ras_n and pin_val are all ones. No more than one pin_val bit is ever low.
- R3: pin_oe[k] is 1 exactly when direction bit k is 1.
- R4: A synchronous reset with rom_on=0 sets the direction bits to 8'h01, so only pin_oe[0] is 1.
- R5: A synchronous reset with rom_on=1 sets the direction bits to 8'h00.
- R6: In area 7, addresses from IO_LO to IO_HI (default 24'hFFFF00 to 24'hFFFFFF) are internal whatever the value of ram_en, so cs_n[7] stays high.
- R7: In area 7, addresses from RAM_LO to RAM_HI (default 24'hFF0000 to 24'hFFEFFF) are internal when ram_en=1. When ram_en=0 they assert cs_n[7]. Other area-7 addresses are always external.
- R8: dram_sel[j] marks area j+2 as DRAM. An access to a marked area drives ras_n[j] low and keeps cs_n[j+2] high. pin_val[k] is cs_n[k] ANDed with the area's ras_n bit for areas 2 to 5, and equals cs_n[k] for the other areas.
- R9: With dir_we=1 at an edge outside reset, dir_wdata is loaded into the direction bits and shows on pin_oe after that edge.
- R10: The values of cs_n, ras_n and pin_val do not depend on the direction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Access address |
| acc | input | 1 | Access strobe, high while an access is present |
| ram_en | input | 1 | On-chip RAM enable |
| rom_on | input | 1 | Operating mode: 1 = on-chip ROM enabled |
| dir_we | input | 1 | Direction register write enable |
| dir_wdata | input | 8 | Direction register write data |
| dram_sel | input | 4 | DRAM designation for areas 2 to 5 (bit j = area j+2) |
| cs_n | output | 8 | Registered active-low chip selects, one per area |
| ras_n | output | 4 | Registered active-low row strobes for areas 2 to 5 |
| pin_val | output | 8 | Registered value driven on each area's pin |
| pin_oe | output | 8 | Per-pin output enable (direction bits) |

## Verification
A wrong area decode, or a wrong view of the internal windows, shows as the wrong select bit, or as a spurious select bit, on the edge right after the access. Every test vector therefore compares all three output vectors one cycle after driving the input. A stale select register would appear as a low bit that remains after an idle edge. A direction register with the wrong reset value or a lost write would show on pin_oe one edge after reset or after the write.

// File: rtl/csgen_pkg.sv
package csgen_pkg;
  localparam int unsigned ADDR_W    = 24;
  localparam int unsigned AREA_W    = 3;
  localparam int unsigned NUM_AREAS = 1 << AREA_W;
  localparam int unsigned DRAM_LO   = 2;
  localparam int unsigned DRAM_N    = 4;
  typedef logic [AREA_W-1:0] area_t;
endpackage

// File: rtl/csgen_decode.sv
module csgen_decode
  import csgen_pkg::*;
#(
  parameter int unsigned     AW     = ADDR_W,
  parameter int unsigned     NA     = NUM_AREAS,
  parameter logic [AW-1:0]   RAM_LO = 24'hFF0000,
  parameter logic [AW-1:0]   RAM_HI = 24'hFFEFFF,
  parameter logic [AW-1:0]   IO_LO  = 24'hFFFF00,
  parameter logic [AW-1:0]   IO_HI  = 24'hFFFFFF
) (
  input  logic [AW-1:0] addr,
  input  logic          acc,
  input  logic          ram_en,
  output logic [NA-1:0] sel
);
  localparam int unsigned NBITS = $clog2(NA);
  localparam int unsigned TOP   = NA - 1;

  logic [NBITS-1:0] area;
  logic             in_ram;
  logic             in_io;
  logic             internal;

  assign area     = addr[AW-1 -: NBITS];
  assign in_ram   = (addr >= RAM_LO) && (addr <= RAM_HI);
  assign in_io    = (addr >= IO_LO) && (addr <= IO_HI);
  assign internal = (area == NBITS'(TOP)) && (in_io || (ram_en && in_ram));

  for (genvar k = 0; k < NA; k++) begin : g_sel
    assign sel[k] = acc && !internal && (area == NBITS'(k));
  end
endmodule

// File: rtl/csgen_dir_reg.sv
module csgen_dir_reg #(
  parameter int unsigned NA = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rom_on,
  input  logic          we,
  input  logic [NA-1:0] wdata,
  output logic [NA-1:0] dir_q
);
  localparam logic [NA-1:0] RST_ROM_OFF = NA'(1);
  localparam logic [NA-1:0] RST_ROM_ON  = '0;

  always_ff @(posedge clk) begin
    if (rst)     dir_q <= rom_on ? RST_ROM_ON : RST_ROM_OFF;
    else if (we) dir_q <= wdata;
  end

  p_rst_romoff_r4: assert property (@(posedge clk)
    rst && !rom_on |=> dir_q == RST_ROM_OFF);
  p_rst_romon_r5: assert property (@(posedge clk)
    rst && rom_on |=> dir_q == RST_ROM_ON);
  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    we |=> dir_q == $past(wdata));
endmodule

// File: rtl/csgen_pin_mux.sv
module csgen_pin_mux #(
  parameter int unsigned NA      = 8,
  parameter int unsigned DRAM_LO = 2,
  parameter int unsigned DRAM_N  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NA-1:0]     sel,
  input  logic [DRAM_N-1:0] dram_sel,
  output logic [NA-1:0]     cs_n,
  output logic [DRAM_N-1:0] ras_n,
  output logic [NA-1:0]     pin_val
);
  for (genvar k = 0; k < NA; k++) begin : g_pin
    if (k >= DRAM_LO && k < DRAM_LO + DRAM_N) begin : g_dram
      localparam int unsigned J = k - DRAM_LO;
      always_ff @(posedge clk) begin
        if (rst) begin
          cs_n[k]  <= 1'b1;
          ras_n[J] <= 1'b1;
        end else begin
          cs_n[k]  <= !(sel[k] && !dram_sel[J]);
          ras_n[J] <= !(sel[k] && dram_sel[J]);
        end
      end
      p_dram_swap_r8: assert property (@(posedge clk) disable iff (rst)
        sel[k] && dram_sel[J] |=> !ras_n[J] && cs_n[k]);
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) cs_n[k] <= 1'b1;
        else     cs_n[k] <= !sel[k];
      end
    end
    always_ff @(posedge clk) begin
      if (rst) pin_val[k] <= 1'b1;
      else     pin_val[k] <= !sel[k];
    end
  end
endmodule

// File: rtl/csgen_top.sv
module csgen_top
  import csgen_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_LO = 24'hFF0000,
  parameter logic [ADDR_W-1:0] RAM_HI = 24'hFFEFFF,
  parameter logic [ADDR_W-1:0] IO_LO  = 24'hFFFF00,
  parameter logic [ADDR_W-1:0] IO_HI  = 24'hFFFFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 acc,
  input  logic                 ram_en,
  input  logic                 rom_on,
  input  logic                 dir_we,
  input  logic [NUM_AREAS-1:0] dir_wdata,
  input  logic [DRAM_N-1:0]    dram_sel,
  output logic [NUM_AREAS-1:0] cs_n,
  output logic [DRAM_N-1:0]    ras_n,
  output logic [NUM_AREAS-1:0] pin_val,
  output logic [NUM_AREAS-1:0] pin_oe
);
  localparam int unsigned TOP = NUM_AREAS - 1;

  logic [NUM_AREAS-1:0] sel;
  logic [NUM_AREAS-1:0] dir_q;

  csgen_decode #(
    .AW(ADDR_W), .NA(NUM_AREAS),
    .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .IO_LO(IO_LO), .IO_HI(IO_HI)
  ) i_decode (
    .addr(addr), .acc(acc), .ram_en(ram_en), .sel(sel)
  );

  csgen_dir_reg #(.NA(NUM_AREAS)) i_dir (
    .clk(clk), .rst(rst), .rom_on(rom_on), .we(dir_we),
    .wdata(dir_wdata), .dir_q(dir_q)
  );

  csgen_pin_mux #(.NA(NUM_AREAS), .DRAM_LO(DRAM_LO), .DRAM_N(DRAM_N)) i_mux (
    .clk(clk), .rst(rst), .sel(sel), .dram_sel(dram_sel),
    .cs_n(cs_n), .ras_n(ras_n), .pin_val(pin_val)
  );

  assign pin_oe = dir_q;

  p_one_low_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~pin_val));
  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    !acc |=> (&cs_n) && (&ras_n) && (&pin_val));
  p_io_internal_r6: assert property (@(posedge clk) disable iff (rst)
    acc && addr >= IO_LO && addr <= IO_HI |=> cs_n[TOP] && pin_val[TOP]);
  p_ram_fallthru_r7: assert property (@(posedge clk) disable iff (rst)
    acc && !ram_en && addr >= RAM_LO && addr <= RAM_HI |=> !cs_n[TOP]);
  p_pin_merge_r8: assert property (@(posedge clk) disable iff (rst)
    pin_val == (cs_n & {2'b11, ras_n, 2'b11}));
endmodule

// File: tb/test_csgen_top.sv
module test_csgen_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // {addr, acc, ram_en, dram_sel, exp_cs_n, exp_ras_n}
  localparam logic [41:0] VECS [NV] = '{
    {24'h000100, 1'b1, 1'b1, 4'h0, 8'hFE, 4'hF},
    {24'h3FFFFF, 1'b1, 1'b1, 4'h0, 8'hFD, 4'hF},
    {24'h400000, 1'b1, 1'b1, 4'h0, 8'hFB, 4'hF},
    {24'h400000, 1'b1, 1'b1, 4'h1, 8'hFF, 4'hE},
    {24'hA12345, 1'b1, 1'b1, 4'h8, 8'hFF, 4'h7},
    {24'hA12345, 1'b1, 1'b1, 4'h7, 8'hDF, 4'hF},
    {24'h6ABCDE, 1'b1, 1'b0, 4'h2, 8'hFF, 4'hD},
    {24'hC00000, 1'b1, 1'b1, 4'hF, 8'hBF, 4'hF},
    {24'hE00000, 1'b1, 1'b1, 4'h0, 8'h7F, 4'hF},
    {24'hFF0000, 1'b1, 1'b1, 4'h0, 8'hFF, 4'hF},
    {24'hFF0000, 1'b1, 1'b0, 4'h0, 8'h7F, 4'hF},
    {24'hFFEFFF, 1'b1, 1'b1, 4'h0, 8'hFF, 4'hF},
    {24'hFFF000, 1'b1, 1'b1, 4'h0, 8'h7F, 4'hF},
    {24'hFFFF00, 1'b1, 1'b0, 4'h0, 8'hFF, 4'hF},
    {24'hFFFFFF, 1'b1, 1'b1, 4'h0, 8'hFF, 4'hF},
    {24'h800000, 1'b0, 1'b1, 4'hF, 8'hFF, 4'hF}
  };

  logic        clk = 1'b0;
  logic        rst, acc, ram_en, rom_on, dir_we;
  logic [23:0] addr;
  logic [7:0]  dir_wdata, cs_n, pin_val, pin_oe;
  logic [3:0]  dram_sel, ras_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csgen_top i_csgen_top (
    .clk(clk), .rst(rst), .addr(addr), .acc(acc), .ram_en(ram_en),
    .rom_on(rom_on), .dir_we(dir_we), .dir_wdata(dir_wdata),
    .dram_sel(dram_sel), .cs_n(cs_n), .ras_n(ras_n),
    .pin_val(pin_val), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  function automatic logic [7:0] merge(input logic [7:0] c, input logic [3:0] r);
    return c & {2'b11, r, 2'b11};
  endfunction

  initial begin
    rst = 1'b1; acc = 1'b0; ram_en = 1'b1; rom_on = 1'b0; dir_we = 1'b0;
    addr = '0; dir_wdata = '0; dram_sel = '0;
    tick(); tick();
    check("R4 oe after reset rom off", pin_oe, 8'h01);
    check("R2 cs after reset", cs_n, 8'hFF);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {addr, acc, ram_en, dram_sel} = VECS[i][41:12];
      tick();
      check($sformatf("R1/R6/R7 cs_n vec %0d", i), cs_n, VECS[i][11:4]);
      check($sformatf("R8 ras_n vec %0d", i), {4'h0, ras_n}, {4'h0, VECS[i][3:0]});
      check($sformatf("R8 pin_val vec %0d", i), pin_val, merge(VECS[i][11:4], VECS[i][3:0]));
    end

    // R2: return high after idle
    @(negedge clk); addr = 24'h200000; acc = 1'b1; dram_sel = '0;
    tick();
    check("R1 area1 select", cs_n, 8'hFD);
    @(negedge clk); acc = 1'b0;
    tick();
    check("R2 idle cs high", cs_n, 8'hFF);
    check("R2 idle pin high", pin_val, 8'hFF);

    // R9 / R3: direction write
    @(negedge clk); dir_we = 1'b1; dir_wdata = 8'hA5;
    tick();
    check("R9 dir load", pin_oe, 8'hA5);
    @(negedge clk); dir_we = 1'b0; dir_wdata = 8'h00;
    tick();
    check("R3 oe holds without write", pin_oe, 8'hA5);
    @(negedge clk); dir_we = 1'b1; dir_wdata = 8'h00;
    tick();
    check("R3 oe cleared", pin_oe, 8'h00);
    @(negedge clk); dir_we = 1'b0;

    // R10: selects regardless of direction bits
    @(negedge clk); addr = 24'h600010; acc = 1'b1;
    tick();
    check("R10 cs with oe off", cs_n, 8'hF7);
    check("R10 pin with oe off", pin_val, 8'hF7);
    @(negedge clk); acc = 1'b0;

    // R5: reset in ROM-enabled mode
    @(negedge clk); rst = 1'b1; rom_on = 1'b1;
    tick();
    check("R5 oe after reset rom on", pin_oe, 8'h00);
    @(negedge clk); rom_on = 1'b0;
    tick();
    check("R4 oe reset rom off again", pin_oe, 8'h01);
    @(negedge clk); rst = 1'b0;
    tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule